// File: doc/BRIEF.md
# I2C Memory Target with Random-Address Read

This block is the serial front end of an 8K x 8 byte memory that sits on an I2C bus as a target. It watches oversampled SCL and SDA, finds START, repeated START and STOP conditions, and shifts bytes in and out. It drives SDA only through an open-drain pull-down enable. The target answers to a select byte whose upper nibble is the memory type code and whose next three bits match three strap pins.

A write-direction select byte is followed by two address bytes, which load a 13-bit word pointer. Any further bytes in that transaction are written to the memory at the pointer. A repeated START with a read-direction select byte then streams bytes from the pointer, one per master acknowledge, until the master answers with a NACK. A high-speed master code may come before any transaction. The target leaves it unacknowledged and accepts the select byte that follows the next repeated START.

The memory side is a plain synchronous port. A read strobe returns data on the next clock, and a write strobe carries the data byte. Both use the pointer as the address, and the pointer advances after each access.

Top module: `i2c_nvmem_target`

## Requirements
- R1: A select byte whose bits 7..4 are 1010 and whose bits 3..1 equal `strap[2:0]` is acknowledged by pulling SDA low during the ninth clock. Bit 0 selects the direction: 0 is write and 1 is read.
- R2: A select byte whose type code or strap bits differ is left unacknowledged. SDA stays released for the rest of that transaction, including the acknowledge slots of later bytes, and nothing is written to memory.
- R3: After a write-direction select byte, the next two bytes are acknowledged. The pointer is loaded with bits 4..0 of the first byte as address bits 12..8 and the second byte as bits 7..0. Bits 7..5 of the first byte are ignored.
- R4: Bytes that follow the two address bytes in a write transaction are acknowledged. Each is written to memory at the pointer, and the pointer advances by one after each write.
- R5: After a repeated START and a matching read-direction select byte, the target acknowledges and then sends the byte stored at the pointer, most significant bit first.
- R6: A master ACK after a data byte makes the target send the byte at the next address. A master NACK makes the target release SDA until the next START or STOP.
- R7: The pointer advances after each byte read and wraps from 0x1FFF to 0x0000.
- R8: A master code of the form 00001xxx after START is not acknowledged. A repeated START followed by the normal select, address and read sequence then works as usual.
- R9: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high, both seen on the synchronised inputs. A STOP releases SDA and returns the target to idle.
- R10: The SDA pull-down enable changes only while SCL is low.
- R11: During and right after reset, SDA is released and both memory strobes are low.
- R12: The memory read and write strobes are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad (asynchronous) |
| sda_in | input | 1 | Bus data line as seen at the pad (asynchronous) |
| strap | input | 3 | Address strap pins compared with select byte bits 3..1 |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| mem_addr | output | AW (13) | Memory word address (the pointer) |
| mem_rd_en | output | 1 | One-cycle read strobe; data is expected on the next clock |
| mem_wr_en | output | 1 | One-cycle write strobe |
| mem_wdata | output | 8 | Write data byte |
| mem_rdata | input | 8 | Read data byte, valid one clock after `mem_rd_en` |

## Verification
The bound checker watches rules that hold on every cycle. It checks that the pull-down enable moves only after a synchronised SCL fall or a bus condition, that a STOP releases SDA, that the strobes are exclusive single pulses, and that the address steps by exactly one, modulo 8K, after every read or write. Whether the right bytes are acknowledged, which bytes reach the bus, and how the target handles the master code and mismatched select bytes depend on whole transactions. Only the bench's bus scenarios can show these, including the pointer wrap at 0x1FFF seen through the returned data.

// File: rtl/i2c_tgt_pkg.sv
// Package: shared constants and state encodings for the I2C memory target.
// Assumes byte-wide transfers; the word address width is a parameter of the top.
package i2c_tgt_pkg;

    localparam int          BYTE_W   = 8;
    localparam logic [3:0]  DEV_TYPE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_SKIP
    } tgt_state_e;

    typedef enum logic [1:0] {
        PH_SEL,
        PH_AHI,
        PH_ALO,
        PH_DATA
    } rx_phase_e;

endpackage

// File: rtl/i2c_tgt_sync.sv
// Module: brings SCL and SDA into the clock domain and detects bus events.
// Assumes STAGES >= 2 and a clock at least several times faster than SCL.
// Outputs are derived from the last synchroniser stage and a one-cycle history.
module i2c_tgt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_p;
    logic              sda_p;
    logic              scl_s;

    // Synchroniser chains and one-cycle history; idle bus reads high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_in};
            sda_ff <= {sda_ff[STAGES-2:0], sda_in};
            scl_p  <= scl_ff[STAGES-1];
            sda_p  <= sda_ff[STAGES-1];
        end
    end

    // Edge and bus-condition decode on the synchronised lines.
    always_comb begin
        scl_s     = scl_ff[STAGES-1];
        sda_s     = sda_ff[STAGES-1];
        scl_rise  = scl_s & ~scl_p;
        scl_fall  = ~scl_s & scl_p;
        start_det = scl_s & scl_p & sda_p & ~sda_s;
        stop_det  = scl_s & scl_p & ~sda_p & sda_s;
    end

endmodule

// File: rtl/i2c_tgt_ptr.sv
// Module: word address pointer with parallel load and wrapping increment.
// Assumes load and increment are never requested together; load wins if so.
module i2c_tgt_ptr #(
    parameter int AW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          inc,
    output logic [AW-1:0] ptr
);

    // Pointer register; natural overflow gives the wrap to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (load)
            ptr <= load_val;
        else if (inc)
            ptr <= ptr + AW'(1);
    end

endmodule

// File: rtl/i2c_tgt_ctrl.sv
// Module: bit and byte sequencer of the I2C memory target.
// Receives select and address bytes, produces ACK/NACK, serialises read data
// and issues memory strobes. Assumes synchronised event pulses from the line
// synchroniser and memory read data one clock after the read strobe.
// SDA drive changes only on a synchronised SCL fall or a bus condition.
module i2c_tgt_ctrl
    import i2c_tgt_pkg::*;
#(
    parameter int AW = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [2:0]        strap,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              sda_oe,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              ptr_load,
    output logic [AW-1:0]     ptr_load_val,
    output logic              ptr_inc
);

    localparam int HI_W = AW - BYTE_W;

    tgt_state_e        state;
    rx_phase_e         phase;
    logic [3:0]        cnt;
    logic [BYTE_W-1:0] rx_sr;
    logic [BYTE_W-1:0] tx_sr;
    logic [HI_W-1:0]   hi_stage;
    logic              ack_go;
    logic              ack_half;
    logic              rw;
    logic              rd_pend;

    logic [BYTE_W-1:0] rx_byte;
    logic              sel_match;
    logic              dec_ack;
    logic              dec_rd;
    logic              dec_wr;
    logic              dec_load;
    logic              dec_rw;
    rx_phase_e         dec_phase;

    // Byte as it stands after the bit sampled on the current SCL rise.
    always_comb begin
        rx_byte   = {rx_sr[BYTE_W-2:0], sda_s};
        sel_match = (rx_byte[7:4] == DEV_TYPE) && (rx_byte[3:1] == strap);
    end

    // Per-byte decision: acknowledge, next phase and memory action.
    always_comb begin
        dec_ack   = 1'b0;
        dec_rd    = 1'b0;
        dec_wr    = 1'b0;
        dec_load  = 1'b0;
        dec_rw    = rw;
        dec_phase = phase;
        case (phase)
            PH_SEL: begin
                if (sel_match) begin
                    dec_ack   = 1'b1;
                    dec_rw    = rx_byte[0];
                    dec_rd    = rx_byte[0];
                    dec_phase = PH_AHI;
                end
            end
            PH_AHI: begin
                dec_ack   = 1'b1;
                dec_phase = PH_ALO;
            end
            PH_ALO: begin
                dec_ack   = 1'b1;
                dec_load  = 1'b1;
                dec_phase = PH_DATA;
            end
            default: begin
                dec_ack = 1'b1;
                dec_wr  = 1'b1;
            end
        endcase
    end

    // Main sequencer: bus conditions first, then per-state bit handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            phase        <= PH_SEL;
            cnt          <= '0;
            rx_sr        <= '0;
            tx_sr        <= '0;
            hi_stage     <= '0;
            ack_go       <= 1'b0;
            ack_half     <= 1'b0;
            rw           <= 1'b0;
            rd_pend      <= 1'b0;
            sda_oe       <= 1'b0;
            mem_rd_en    <= 1'b0;
            mem_wr_en    <= 1'b0;
            mem_wdata    <= '0;
            ptr_load     <= 1'b0;
            ptr_load_val <= '0;
            ptr_inc      <= 1'b0;
        end else begin
            mem_rd_en <= 1'b0;
            mem_wr_en <= 1'b0;
            ptr_load  <= 1'b0;
            ptr_inc   <= 1'b0;
            rd_pend   <= mem_rd_en;
            if (start_det) begin
                state    <= ST_RX;
                phase    <= PH_SEL;
                cnt      <= '0;
                ack_half <= 1'b0;
                sda_oe   <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_RX: begin
                        if (scl_rise) begin
                            rx_sr <= rx_byte;
                            if (cnt == 4'd7) begin
                                cnt       <= '0;
                                state     <= ST_RX_ACK;
                                ack_go    <= dec_ack;
                                ack_half  <= 1'b0;
                                phase     <= dec_phase;
                                rw        <= dec_rw;
                                mem_rd_en <= dec_rd;
                                mem_wr_en <= dec_wr;
                                ptr_inc   <= dec_rd | dec_wr;
                                ptr_load  <= dec_load;
                                mem_wdata <= rx_byte;
                                ptr_load_val <= {hi_stage, rx_byte};
                                if (phase == PH_AHI)
                                    hi_stage <= rx_byte[HI_W-1:0];
                            end else begin
                                cnt <= cnt + 4'd1;
                            end
                        end
                    end
                    ST_RX_ACK: begin
                        if (scl_fall) begin
                            if (!ack_half) begin
                                sda_oe   <= ack_go;
                                ack_half <= 1'b1;
                            end else begin
                                ack_half <= 1'b0;
                                if (!ack_go) begin
                                    sda_oe <= 1'b0;
                                    state  <= ST_SKIP;
                                end else if (rw) begin
                                    sda_oe <= ~tx_sr[BYTE_W-1];
                                    cnt    <= '0;
                                    state  <= ST_TX;
                                end else begin
                                    sda_oe <= 1'b0;
                                    state  <= ST_RX;
                                end
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) begin
                            cnt <= cnt + 4'd1;
                        end else if (scl_fall) begin
                            if (cnt == 4'd8) begin
                                sda_oe   <= 1'b0;
                                ack_half <= 1'b0;
                                state    <= ST_TX_ACK;
                            end else begin
                                tx_sr  <= {tx_sr[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~tx_sr[BYTE_W-2];
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (!ack_half) begin
                            if (scl_rise) begin
                                if (!sda_s) begin
                                    mem_rd_en <= 1'b1;
                                    ptr_inc   <= 1'b1;
                                    ack_half  <= 1'b1;
                                end else begin
                                    state <= ST_SKIP;
                                end
                            end
                        end else if (scl_fall) begin
                            ack_half <= 1'b0;
                            sda_oe   <= ~tx_sr[BYTE_W-1];
                            cnt      <= '0;
                            state    <= ST_TX;
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
            // Read data lands in the transmit register one clock after the strobe.
            if (rd_pend)
                tx_sr <= mem_rdata;
        end
    end

endmodule

// File: rtl/i2c_nvmem_target.sv
// Module: top of the I2C memory target (select decode, address pointer,
// random and sequential reads, writes after the address bytes).
// Assumes an external open-drain pad: sda_oe = 1 pulls SDA low.
// Memory port: synchronous, read data valid one clock after mem_rd_en.
module i2c_nvmem_target
    import i2c_tgt_pkg::*;
#(
    parameter int AW          = 13,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [2:0]        strap,
    output logic              sda_oe,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata
);

    logic          sda_s;
    logic          scl_rise;
    logic          scl_fall;
    logic          start_det;
    logic          stop_det;
    logic          ptr_load;
    logic          ptr_inc;
    logic [AW-1:0] ptr_load_val;

    i2c_tgt_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_tgt_ctrl #(
        .AW (AW)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .sda_s        (sda_s),
        .scl_rise     (scl_rise),
        .scl_fall     (scl_fall),
        .start_det    (start_det),
        .stop_det     (stop_det),
        .strap        (strap),
        .mem_rdata    (mem_rdata),
        .sda_oe       (sda_oe),
        .mem_rd_en    (mem_rd_en),
        .mem_wr_en    (mem_wr_en),
        .mem_wdata    (mem_wdata),
        .ptr_load     (ptr_load),
        .ptr_load_val (ptr_load_val),
        .ptr_inc      (ptr_inc)
    );

    i2c_tgt_ptr #(
        .AW (AW)
    ) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_val (ptr_load_val),
        .inc      (ptr_inc),
        .ptr      (mem_addr)
    );

endmodule

// File: rtl/i2c_tgt_checker.sv
// Module: protocol and memory-port assertions for the I2C memory target,
// bound into the top. Observes only; drives nothing.
module i2c_tgt_checker #(
    parameter int AW = 13
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sda_oe,
    input logic          scl_fall,
    input logic          start_det,
    input logic          stop_det,
    input logic          mem_rd_en,
    input logic          mem_wr_en,
    input logic [AW-1:0] mem_addr
);

    // R10: drive changes only follow an SCL fall or a bus condition.
    p_oe_on_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det)));

    // R9: a STOP leaves SDA released.
    p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R12: strobes are exclusive.
    p_strobe_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    // R12: read strobe is a single-cycle pulse.
    p_rd_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    // R12: write strobe is a single-cycle pulse.
    p_wr_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |=> !mem_wr_en);

    // R7: address steps by one, modulo the memory size, after a read.
    p_rd_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> (mem_addr == $past(mem_addr) + AW'(1)));

    // R4: address steps by one after a write.
    p_wr_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |=> (mem_addr == $past(mem_addr) + AW'(1)));

endmodule

bind i2c_nvmem_target i2c_tgt_checker #(
    .AW (AW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_oe    (sda_oe),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .mem_rd_en (mem_rd_en),
    .mem_wr_en (mem_wr_en),
    .mem_addr  (mem_addr)
);

// File: tb/i2c_nvmem_target_bench.sv
module i2c_nvmem_target_bench;

    localparam int         AW    = 13;
    localparam int         Q     = 10;
    localparam logic [2:0] STRAP = 3'b101;

    typedef struct packed {
        logic       hs;
        logic [7:0] ahi;
        logic [7:0] alo;
        logic [3:0] cnt;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{1'b0, 8'h00, 8'h10, 4'd1},
        '{1'b0, 8'hE3, 8'h45, 4'd4},
        '{1'b0, 8'h1F, 8'hFE, 4'd4},
        '{1'b1, 8'h0A, 8'hBC, 4'd2},
        '{1'b1, 8'hFF, 8'hFF, 4'd2}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic [AW-1:0] mem_addr;
    logic mem_rd_en, mem_wr_en;
    logic [7:0] mem_wdata;
    logic [7:0] mem_rdata = 8'h00;
    wire  sda_line = sda_m & ~sda_oe;

    int n_tests = 0;
    int n_fail  = 0;
    int both_hits = 0;
    int oe_viol   = 0;
    logic oe_prev = 1'b0;
    logic [AW-1:0] wl_addr [4];
    logic [7:0]    wl_data [4];
    int wl_n = 0;

    always #5 clk = ~clk;

    i2c_nvmem_target u_i2c_nvmem_target (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_m),
        .sda_in    (sda_line),
        .strap     (STRAP),
        .sda_oe    (sda_oe),
        .mem_addr  (mem_addr),
        .mem_rd_en (mem_rd_en),
        .mem_wr_en (mem_wr_en),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

    function automatic logic [7:0] pat(input logic [AW-1:0] a);
        return a[7:0] ^ {3'b000, a[12:8]} ^ 8'h5A;
    endfunction

    // Memory model and write log.
    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= pat(mem_addr);
        if (mem_wr_en && wl_n < 4) begin
            wl_addr[wl_n] <= mem_addr;
            wl_data[wl_n] <= mem_wdata;
            wl_n <= wl_n + 1;
        end
    end

    // Port monitors for R10 and R12.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_rd_en && mem_wr_en) both_hits++;
            if (sda_oe !== oe_prev && scl_m) oe_viol++;
        end
        oe_prev = sda_oe;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hold();
        scl_m = 1'b1; hold();
        sda_m = 1'b0; hold();
        scl_m = 1'b0; hold();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hold();
        scl_m = 1'b1; hold();
        sda_m = 1'b1; hold();
    endtask

    task automatic bit_out(input logic b);
        sda_m = b; hold();
        scl_m = 1'b1; hold(); hold();
        scl_m = 1'b0; hold();
    endtask

    task automatic bit_in(output logic b);
        sda_m = 1'b1; hold();
        scl_m = 1'b1; hold();
        b = sda_line; hold();
        scl_m = 1'b0; hold();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic x;
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        bit_in(x);
        acked = ~x;
    endtask

    task automatic recv_byte(input logic ack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) bit_in(d[i]);
        bit_out(~ack);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        finish_run();
    end

    initial begin
        logic ack;
        logic [7:0] d;
        logic [AW-1:0] p;
        int wbase;

        // R11: reset state.
        repeat (5) @(negedge clk);
        check(!sda_oe && !mem_rd_en && !mem_wr_en, "R11 reset outputs", {sda_oe, mem_rd_en, mem_wr_en}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(!sda_oe && !mem_rd_en && !mem_wr_en, "R11 after reset", {sda_oe, mem_rd_en, mem_wr_en}, 0);

        // Vector table: random-address reads, plain and after a master code.
        for (int v = 0; v < 5; v++) begin
            bus_start();
            if (VECS[v].hs) begin
                send_byte(8'h0D, ack);
                check(!ack, "R8 master code not acknowledged", ack, 0);
                bus_start();
            end
            send_byte({4'b1010, STRAP, 1'b0}, ack);
            check(ack, "R1 write select acknowledged", ack, 1);
            send_byte(VECS[v].ahi, ack);
            check(ack, "R3 high address acknowledged", ack, 1);
            send_byte(VECS[v].alo, ack);
            check(ack, "R3 low address acknowledged", ack, 1);
            bus_start();
            send_byte({4'b1010, STRAP, 1'b1}, ack);
            check(ack, "R5 read select acknowledged", ack, 1);
            p = {VECS[v].ahi[4:0], VECS[v].alo};
            for (int j = 0; j < int'(VECS[v].cnt); j++) begin
                recv_byte(j != int'(VECS[v].cnt) - 1, d);
                if (j == 0)
                    check(d == pat(p), "R5 first read byte", d, pat(p));
                else
                    check(d == pat(p + AW'(j)), "R6 R7 sequential read byte", d, pat(p + AW'(j)));
            end
            check(!sda_oe, "R6 released after master NACK", sda_oe, 0);
            bus_stop();
            check(!sda_oe, "R9 released after STOP", sda_oe, 0);
        end

        // R2: strap mismatch, then a further byte also left alone.
        wbase = wl_n;
        bus_start();
        send_byte({4'b1010, STRAP ^ 3'b010, 1'b0}, ack);
        check(!ack, "R2 strap mismatch not acknowledged", ack, 0);
        send_byte(8'h00, ack);
        check(!ack, "R2 later byte ignored", ack, 0);
        send_byte(8'h00, ack);
        check(!ack, "R2 later byte ignored", ack, 0);
        bus_stop();
        check(wl_n == wbase, "R2 no memory write", wl_n, wbase);

        // R2: wrong type code.
        bus_start();
        send_byte({4'b1011, STRAP, 1'b1}, ack);
        check(!ack, "R2 type code mismatch not acknowledged", ack, 0);
        bus_stop();
        check(!sda_oe, "R9 idle after STOP", sda_oe, 0);

        // R4: write two data bytes after the address.
        bus_start();
        send_byte({4'b1010, STRAP, 1'b0}, ack);
        check(ack, "R1 select before write", ack, 1);
        send_byte(8'hA1, ack);
        send_byte(8'h20, ack);
        send_byte(8'hA5, ack);
        check(ack, "R4 data byte acknowledged", ack, 1);
        send_byte(8'h3C, ack);
        check(ack, "R4 data byte acknowledged", ack, 1);
        bus_stop();
        check(wl_n == 2, "R4 write count", wl_n, 2);
        check(wl_addr[0] == 13'h0120 && wl_data[0] == 8'hA5, "R4 first write", {wl_addr[0], wl_data[0]}, {13'h0120, 8'hA5});
        check(wl_addr[1] == 13'h0121 && wl_data[1] == 8'h3C, "R4 second write", {wl_addr[1], wl_data[1]}, {13'h0121, 8'h3C});

        // R10 and R12 from the port monitors.
        check(oe_viol == 0, "R10 drive changed while SCL high", oe_viol, 0);
        check(both_hits == 0, "R12 strobes overlapped", both_hits, 0);

        repeat (20) @(negedge clk);
        finish_run();
    end

endmodule